// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Bank

This block keeps the traffic statistics of one Ethernet switch port. The receive and transmit MACs each send a single-cycle strobe for every finished frame. The strobe carries the frame length and a set of classification flags. The bank bumps one counter for each flag that is set. It files the frame into one length bucket and adds the length to a byte total. It holds 39 counters. Most are 32 bits wide. The two receive byte totals and the transmit byte total are 64 bits wide.

Software reads the bank one 32-bit word at a time, through a word-addressed read port with a latency of one cycle. A 64-bit counter fills two neighbouring words, with the low word first. Reading the low word captures the matching high word, so the two halves always belong together. A control write with both the flush bit and the busy bit set starts a clear of the whole bank. The clear takes one counter per cycle, and `flushBusy` stays high until it is done.

Top module: `statbank_top`

## Requirements
- R1: Counters sit in a fixed order at word indices 0 to 41 (byte offset = 4 × `rdWord`). Each 32-bit counter takes one word. Counters 15, 16 and 31 are 64 bits wide and take two words, with the low word at the lower index. `rdData` changes on the clock edge that samples `rdEn` and then holds.
- R2: Receive flag bits are: 0 broadcast, 1 pause, 2 multicast, 3 FCS error, 4 alignment error, 5 runt, 6 fragment, 7 too long, 8 overflow, 9 filtered. Bits 0–6 bump counters 0–6. Bit 7 bumps counter 14, bit 8 bumps counter 17 and bit 9 bumps counter 18, each by one per strobe.
- R3: Transmit flag bits are: 0 broadcast, 1 pause, 2 multicast, 3 underrun, 4 oversize, 5 collision, 6 abort collision, 7 multiple collision, 8 single collision, 9 excessive deferral, 10 deferral, 11 late collision. Bits 0–3 bump counters 19–22, bit 4 bumps counter 30, and bits 5–11 bump counters 32–38.
- R4: Each strobe bumps exactly one length bucket: counters 7–13 for receive and 23–29 for transmit, for thresholds 64, 128, 256, 512, 1024, 1518 and max. The bucket is the largest threshold not above the length. Lengths under 64 go to the 64 bucket, and lengths over 1518 go to the max bucket.
- R5: A receive strobe adds its length to the bad-byte counter (16) when any of flag bits 3–7 is set, and to the good-byte counter (15) otherwise. Every transmit strobe adds its length to counter 31. Byte counters carry across the 32-bit word boundary.
- R6: A read of the high word of a 64-bit counter returns the value that the high half had at the most recent read of the same counter's low word.
- R7: `ctrlWrData` bit 1 is the flush bit and bit 0 is the busy bit. A write with both set, made while the bank is idle, raises `flushBusy` on the next edge. `flushBusy` stays high for exactly 39 cycles and leaves every counter at zero. A write with only one of the two bits set does nothing.
- R8: Strobes that arrive while `flushBusy` is high are dropped. A control write during a flush neither restarts nor extends it.
- R9: Receive and transmit strobes in the same cycle are both counted. A read in the same cycle as an increment returns the value before that increment.
- R10: A read of a word index from 42 to 63 returns zero.
- R11: After reset every counter reads zero and `flushBusy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxStb | input | 1 | Receive frame event strobe |
| rxLen | input | LEN_W | Receive frame length in bytes |
| rxFlags | input | 10 | Receive classification flags |
| txStb | input | 1 | Transmit frame event strobe |
| txLen | input | LEN_W | Transmit frame length in bytes |
| txFlags | input | 12 | Transmit classification flags |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWrData | input | 2 | Control write data (bit 1 flush, bit 0 busy) |
| flushBusy | output | 1 | High while a flush is clearing the bank |
| rdEn | input | 1 | Read request |
| rdWord | input | 6 | Word index of the read |
| rdData | output | 32 | Registered read data |

## Verification
Three kinds of activity can fall on the same cycle and must not disturb each other: a read of a counter and an increment of that same counter, a receive strobe and a transmit strobe, and a flush start together with an event. The bench provokes each case by driving the inputs together at one falling edge. The scoreboard takes a snapshot of the expected read value before it applies the event to its model, so a same-cycle read must return the old count. A later read must show the new count. For the flush case, the event that arrives with the start is counted and then cleared, and events during the 39 busy cycles must leave every word at zero.

// File: rtl/statbank_pkg.sv
package statbank_pkg;
  localparam int NUM_CNT    = 39;
  localparam int NUM_WORDS  = 42;
  localparam int CNT_IDX_W  = $clog2(NUM_CNT);
  localparam int WORD_IDX_W = 6;
  localparam int RX_FLAG_N  = 10;
  localparam int TX_FLAG_N  = 12;
  localparam int CTRL_W     = 2;
  localparam int CTRL_FLUSH = 1;
  localparam int CTRL_BUSY  = 0;

  // counter indices whose position matters to decode (R1)
  localparam int RX_BKT0       = 7;
  localparam int RX_TOO_LONG   = 14;
  localparam int RX_GOOD_BYTES = 15;
  localparam int RX_BAD_BYTES  = 16;
  localparam int RX_OVERFLOW   = 17;
  localparam int TX_BASE       = 19;
  localparam int TX_BKT0       = 23;
  localparam int TX_OVERSIZE   = 30;
  localparam int TX_BYTES      = 31;
  localparam int TX_COLL0      = 32;

  localparam logic [RX_FLAG_N-1:0] RX_BAD_MASK = 10'b00_1111_1000;

  typedef struct packed {
    logic [NUM_CNT-1:0]   inc;
    logic                 clr;
    logic [CNT_IDX_W-1:0] clrIdx;
  } ctlStrobes_t;

  function automatic bit isWide(int idx);
    return (idx == RX_GOOD_BYTES) || (idx == RX_BAD_BYTES) || (idx == TX_BYTES);
  endfunction

  function automatic int rxFlagSlot(int b);
    if (b < 7) return b;
    if (b == 7) return RX_TOO_LONG;
    return RX_OVERFLOW + (b - 8);
  endfunction

  function automatic int txFlagSlot(int b);
    if (b < 4) return TX_BASE + b;
    if (b == 4) return TX_OVERSIZE;
    return TX_COLL0 + (b - 5);
  endfunction

  // largest threshold not above len; short frames to first, long to max (R4)
  function automatic int lenBucket(int unsigned len);
    if (len > 1518) return 6;
    if (len == 1518) return 5;
    if (len >= 1024) return 4;
    if (len >= 512) return 3;
    if (len >= 256) return 2;
    if (len >= 128) return 1;
    return 0;
  endfunction
endpackage

// File: rtl/statbank_ctl.sv
module statbank_ctl
  import statbank_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxStb,
  input  logic [LEN_W-1:0]     rxLen,
  input  logic [RX_FLAG_N-1:0] rxFlags,
  input  logic                 txStb,
  input  logic [LEN_W-1:0]     txLen,
  input  logic [TX_FLAG_N-1:0] txFlags,
  input  logic                 ctrlWr,
  input  logic [CTRL_W-1:0]    ctrlWrData,
  output ctlStrobes_t          strb,
  output logic                 flushBusy
);
  logic                 busy;
  logic [CNT_IDX_W-1:0] clrIdx;
  logic                 startFlush;

  // R7: both control bits needed; R8: ignored while busy
  assign startFlush = ctrlWr && ctrlWrData[CTRL_FLUSH] && ctrlWrData[CTRL_BUSY] && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      clrIdx <= '0;
    end else if (busy) begin
      clrIdx <= clrIdx + 1'b1;
      if (clrIdx == CNT_IDX_W'(NUM_CNT - 1)) busy <= 1'b0;
    end else if (startFlush) begin
      busy   <= 1'b1;
      clrIdx <= '0;
    end
  end

  // event decode; events dropped during flush (R8)
  always_comb begin
    strb.inc = '0;
    if (!busy && rxStb) begin
      for (int b = 0; b < RX_FLAG_N; b++)
        if (rxFlags[b]) strb.inc[rxFlagSlot(b)] = 1'b1;
      strb.inc[RX_BKT0 + lenBucket(32'(rxLen))] = 1'b1;
      if (|(rxFlags & RX_BAD_MASK)) strb.inc[RX_BAD_BYTES] = 1'b1;
      else                          strb.inc[RX_GOOD_BYTES] = 1'b1;
    end
    if (!busy && txStb) begin
      for (int b = 0; b < TX_FLAG_N; b++)
        if (txFlags[b]) strb.inc[txFlagSlot(b)] = 1'b1;
      strb.inc[TX_BKT0 + lenBucket(32'(txLen))] = 1'b1;
      strb.inc[TX_BYTES] = 1'b1;
    end
    strb.clr    = busy;
    strb.clrIdx = clrIdx;
  end

  assign flushBusy = busy;
endmodule

// File: rtl/statbank_dp.sv
module statbank_dp
  import statbank_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strb,
  input  logic [LEN_W-1:0]      rxLen,
  input  logic [LEN_W-1:0]      txLen,
  input  logic                  rdEn,
  input  logic [WORD_IDX_W-1:0] rdWord,
  output logic [31:0]           rdData
);
  logic [63:0] cntVal [NUM_CNT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam bit WIDE = isWide(i);
    logic hitClr;
    assign hitClr = strb.clr && (strb.clrIdx == CNT_IDX_W'(i));
    if (WIDE) begin : g_wide
      logic [63:0] acc;
      logic [63:0] addend;
      assign addend = (i >= TX_BASE) ? 64'(txLen) : 64'(rxLen);
      always_ff @(posedge clk) begin
        if (!rstN)            acc <= '0;
        else if (hitClr)      acc <= '0;
        else if (strb.inc[i]) acc <= acc + addend;  // R5
      end
      assign cntVal[i] = acc;
    end else begin : g_narrow
      logic [31:0] acc;
      always_ff @(posedge clk) begin
        if (!rstN)            acc <= '0;
        else if (hitClr)      acc <= '0;
        else if (strb.inc[i]) acc <= acc + 32'd1;   // wraps modulo 2^32
      end
      assign cntVal[i] = {32'd0, acc};
    end
  end

  // word index to counter decode (R1)
  logic                 inRange;
  logic                 rdHi;
  logic                 rdIsWide;
  logic [CNT_IDX_W-1:0] rdIdx;
  logic [1:0]           slot;
  logic [31:0]          hiShadow [3];

  always_comb begin
    int w;
    int k;
    w        = int'(rdWord);
    inRange  = (w < NUM_WORDS);
    k        = w - int'(w >= 16) - int'(w >= 18) - int'(w >= 34);
    if (!inRange) k = 0;
    rdIdx    = CNT_IDX_W'(k);
    rdHi     = inRange && ((w == 16) || (w == 18) || (w == 34));
    rdIsWide = isWide(k);
    slot     = (k == RX_GOOD_BYTES) ? 2'd0 : (k == RX_BAD_BYTES) ? 2'd1 : 2'd2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      for (int s = 0; s < 3; s++) hiShadow[s] <= '0;
    end else if (rdEn) begin
      if (!inRange) rdData <= '0;                  // R10
      else if (rdHi) rdData <= hiShadow[slot];     // R6
      else begin
        rdData <= cntVal[rdIdx][31:0];             // R9: pre-increment value
        if (rdIsWide) hiShadow[slot] <= cntVal[rdIdx][63:32];
      end
    end
  end
endmodule

// File: rtl/statbank_top.sv
module statbank_top
  import statbank_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxStb,
  input  logic [LEN_W-1:0]      rxLen,
  input  logic [RX_FLAG_N-1:0]  rxFlags,
  input  logic                  txStb,
  input  logic [LEN_W-1:0]      txLen,
  input  logic [TX_FLAG_N-1:0]  txFlags,
  input  logic                  ctrlWr,
  input  logic [CTRL_W-1:0]     ctrlWrData,
  output logic                  flushBusy,
  input  logic                  rdEn,
  input  logic [WORD_IDX_W-1:0] rdWord,
  output logic [31:0]           rdData
);
  ctlStrobes_t strb;

  statbank_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .rxStb(rxStb), .rxLen(rxLen), .rxFlags(rxFlags),
    .txStb(txStb), .txLen(txLen), .txFlags(txFlags),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .strb(strb), .flushBusy(flushBusy)
  );

  statbank_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxLen(rxLen), .txLen(txLen),
    .rdEn(rdEn), .rdWord(rdWord), .rdData(rdData)
  );
endmodule

// File: rtl/statbank_chk.sv
module statbank_chk
  import statbank_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  ctrlWr,
  input logic [CTRL_W-1:0]     ctrlWrData,
  input logic                  flushBusy,
  input logic                  rdEn,
  input logic [WORD_IDX_W-1:0] rdWord,
  input logic [31:0]           rdData
);
  logic [6:0] busyRun;
  logic       fullStart;

  assign fullStart = ctrlWr && ctrlWrData[CTRL_FLUSH] && ctrlWrData[CTRL_BUSY];

  always_ff @(posedge clk) begin
    if (!rstN)          busyRun <= '0;
    else if (flushBusy) busyRun <= busyRun + 7'd1;
    else                busyRun <= '0;
  end

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (fullStart && !flushBusy) |=> flushBusy);

  a_r7_no_spurious_start: assert property (@(posedge clk) disable iff (!rstN)
    (!flushBusy && !fullStart) |=> !flushBusy);

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushBusy) |-> (busyRun == 7'(NUM_CNT)));

  a_r8_no_early_end: assert property (@(posedge clk) disable iff (!rstN)
    (flushBusy && busyRun < 7'(NUM_CNT - 1)) |=> flushBusy);

  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(rdWord) >= NUM_WORDS) |=> (rdData == 32'd0));
endmodule

bind statbank_top statbank_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
  .flushBusy(flushBusy), .rdEn(rdEn), .rdWord(rdWord), .rdData(rdData)
);

// File: tb/tb_statbank_top.sv
module tb_statbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxStb = 1'b0, txStb = 1'b0, ctrlWr = 1'b0, rdEn = 1'b0;
  logic [LEN_W-1:0] rxLen = '0, txLen = '0;
  logic [9:0] rxFlags = '0;
  logic [11:0] txFlags = '0;
  logic [1:0] ctrlWrData = '0;
  logic [5:0] rdWord = '0;
  logic flushBusy;
  logic [31:0] rdData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  statbank_top #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .rxStb(rxStb), .rxLen(rxLen), .rxFlags(rxFlags),
    .txStb(txStb), .txLen(txLen), .txFlags(txFlags), .ctrlWr(ctrlWr),
    .ctrlWrData(ctrlWrData), .flushBusy(flushBusy), .rdEn(rdEn),
    .rdWord(rdWord), .rdData(rdData)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int nTests = 0, nFail = 0;
  logic [63:0] mdl [39];
  logic [31:0] shadow [3];
  int wordCnt [42];
  bit wordHi [42];
  int dropLeft = 0;
  bit pendFlush = 0;
  logic rdPend = 1'b0;
  int rxMap [10] = '{0, 1, 2, 3, 4, 5, 6, 14, 17, 18};
  int txMap [12] = '{19, 20, 21, 22, 30, 32, 33, 34, 35, 36, 37, 38};

  function automatic bit wide(int c);
    return c == 15 || c == 16 || c == 31;
  endfunction

  function automatic int slotOf(int c);
    return c == 15 ? 0 : (c == 16 ? 1 : 2);
  endfunction

  function automatic int bkt(int len);
    int thr [6] = '{128, 256, 512, 1024, 1518, 1519};
    int b = 0;
    for (int i = 0; i < 6; i++) if (len >= thr[i]) b = i + 1;
    return b;
  endfunction

  function automatic string tagFor(int c);
    if (wide(c)) return "R1/R5";
    if ((c >= 7 && c <= 13) || (c >= 23 && c <= 29)) return "R1/R4";
    if (c < 19) return "R1/R2";
    return "R1/R3";
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rxSet(int len, logic [9:0] f);
    rxStb = 1'b1; rxLen = LEN_W'(len); rxFlags = f;
    if (dropLeft == 0) begin
      for (int b = 0; b < 10; b++) if (f[b]) mdl[rxMap[b]] = mdl[rxMap[b]] + 1;
      mdl[7 + bkt(len)] = mdl[7 + bkt(len)] + 1;
      if (|f[7:3]) mdl[16] = mdl[16] + 64'(len);
      else         mdl[15] = mdl[15] + 64'(len);
    end
  endtask

  task automatic txSet(int len, logic [11:0] f);
    txStb = 1'b1; txLen = LEN_W'(len); txFlags = f;
    if (dropLeft == 0) begin
      for (int b = 0; b < 12; b++) if (f[b]) mdl[txMap[b]] = mdl[txMap[b]] + 1;
      mdl[23 + bkt(len)] = mdl[23 + bkt(len)] + 1;
      mdl[31] = mdl[31] + 64'(len);
    end
  endtask

  task automatic ctrlSet(logic [1:0] d);
    ctrlWr = 1'b1; ctrlWrData = d;
    if (d == 2'b11 && dropLeft == 0) pendFlush = 1;
  endtask

  task automatic rdSet(int w, string tag);
    item_t it;
    rdEn = 1'b1; rdWord = 6'(w);
    it.tag = tag;
    if (w >= 42) it.exp = '0;
    else if (wordHi[w]) it.exp = shadow[slotOf(wordCnt[w])];
    else begin
      it.exp = mdl[wordCnt[w]][31:0];
      if (wide(wordCnt[w])) shadow[slotOf(wordCnt[w])] = mdl[wordCnt[w]][63:32];
    end
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    rxStb = 1'b0; txStb = 1'b0; rdEn = 1'b0; ctrlWr = 1'b0;
    if (dropLeft > 0) dropLeft--;
    if (pendFlush) begin
      pendFlush = 0; dropLeft = 39;
      for (int c = 0; c < 39; c++) mdl[c] = '0;
    end
  endtask

  task automatic readAll(string tag);
    for (int w = 0; w < 42; w++) begin
      rdSet(w, tag == "" ? tagFor(wordCnt[w]) : tag);
      tick();
    end
    tick();
  endtask

  // scoreboard monitor
  always @(posedge clk) rdPend <= rdEn;
  always @(negedge clk) begin
    if (rdPend) begin
      if (sbq.size() == 0) check("R1", 64'(rdData), 64'hdead);
      else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, 64'(rdData), 64'(it.exp));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int w = 0;
    for (int c = 0; c < 39; c++) begin
      mdl[c] = '0;
      wordCnt[w] = c; wordHi[w] = 0; w++;
      if (wide(c)) begin wordCnt[w] = c; wordHi[w] = 1; w++; end
    end
    for (int s = 0; s < 3; s++) shadow[s] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    check("R11", 64'(flushBusy), 64'd0);
    readAll("R11");
    rdSet(42, "R10"); tick();
    rdSet(63, "R10"); tick(); tick();

    // receive patterns: R2 R4 R5
    rxSet(64, 10'h001);  tick();
    rxSet(100, 10'h00c); tick();
    rxSet(1518, 10'h002); tick();
    rxSet(1519, 10'h080); tick();
    rxSet(40, 10'h060);  tick();
    rxSet(512, 10'h010); tick();
    rxSet(300, 10'h100); tick();
    rxSet(1024, 10'h200); tick();
    rxSet(127, 10'h000); tick();
    rxSet(1517, 10'h3ff); tick();
    readAll("");

    // transmit patterns: R3 R4
    txSet(63, 12'h001);   tick();
    txSet(128, 12'h006);  tick();
    txSet(255, 12'h008);  tick();
    txSet(2000, 12'h010); tick();
    txSet(700, 12'h0e0);  tick();
    txSet(1500, 12'h f00); tick();
    txSet(1518, 12'h000); tick();
    readAll("");

    // R9: same-cycle read and increment, rx and tx together
    rdSet(21, "R9"); txSet(200, 12'h001); tick();
    rdSet(21, "R9"); rxSet(64, 10'h001); txSet(64, 12'h001); tick();
    rdSet(0, "R9"); tick();
    rdSet(21, "R9"); tick(); tick();

    // R7: partial control writes do nothing
    ctrlSet(2'b10); tick();
    check("R7", 64'(flushBusy), 64'd0);
    ctrlSet(2'b01); tick();
    check("R7", 64'(flushBusy), 64'd0);
    rdSet(0, "R7"); tick(); tick();

    // R7/R8: full flush with event at start and events during it
    ctrlSet(2'b11); rxSet(64, 10'h001); tick();
    check("R7", 64'(flushBusy), 64'd1);
    for (int k = 1; k < 39; k++) begin
      if (k == 5) rxSet(900, 10'h3ff);
      if (k == 6) ctrlSet(2'b11);
      if (k == 20) txSet(80, 12'hfff);
      tick();
    end
    check("R7", 64'(flushBusy), 64'd1);
    txSet(90, 12'h001); tick();
    check("R8", 64'(flushBusy), 64'd0);
    readAll("R8");
    rxSet(64, 10'h001); tick();
    rdSet(0, "R8"); tick(); tick();

    // R5/R6: drive byte counters across the 32-bit boundary
    for (int n = 0; n < 65537; n++) begin
      txSet(65535, 12'h000);
      if (n == 0) rxSet(65535, 10'h000);
      tick();
    end
    rdSet(33, "R6"); tick();
    txSet(1, 12'h000); tick();
    rdSet(34, "R6"); tick();
    rdSet(33, "R5"); tick();
    rdSet(34, "R5"); tick(); tick();
    readAll("");

    tick();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule